// File: doc/BRIEF.md
# Framing-State Change Interrupt Controller

This block follows the framing condition of a receive framer through three levels (Out-of-Frame, Un-framed, In-frame) and reports it two ways. It drives level status (two pins plus a readable two-bit state field). It also latches a sticky flag for each kind of framing change. A framer core feeds it single-cycle event strobes. Software sees the block through a byte-wide register port with address, read strobe, write strobe and data lines. Read data is combinational and is valid in the same cycle as the read strobe.

The two change flags can each be masked. Any enabled pending flag sets one bit of a bit-mapped interrupt summary register, so an interrupt handler can find the framing source quickly. Six other request lines and a latched one-second tick share the summary register. An active-high interrupt line is raised whenever any summary bit is set. There is no streaming data path: every pin is a plain control or status level, and the register port has no back-pressure.

Top module: `frm_irq_ctrl`

## Requirements
- R1: After reset the state is Out-of-Frame: `lof_pin`=0, `oof_pin`=1, `irq`=0, the enable register reads 00h and the flag register reads 00h.
- R2: From Out-of-Frame, `evt_lof_timeout` moves to Un-framed. From Un-framed, `evt_frame_acq` moves to In-frame. From In-frame, `evt_frame_err` moves to Out-of-Frame. Every other strobe is ignored. A new state is visible the cycle after the strobe.
- R3: The state register at 44h shows the state in bits 2:1: 00 for In-frame, 11 for Un-framed, 10 for Out-of-Frame. Its other bits read 0. `lof_pin` is 1 only in Un-framed, and `oof_pin` is 0 only in In-frame.
- R4: Bit 0 of the flag register at 46h sets on Out-of-Frame to Un-framed and on Un-framed to In-frame.
- R5: Bit 1 of the flag register sets on Un-framed to In-frame and on In-frame to Out-of-Frame. Bits 7:2 read 0.
- R6: A flag is cleared by the read that returns it as 1. If a setting event lands in the same cycle as that read, the flag stays set.
- R7: The enable register at 47h uses the flag register's layout (bits 1:0), resets to 0 and reads back, with bits 7:2 reading 0. Flags latch whatever the enables are. Summary bit 6 is 1 exactly when some flag is set together with its enable.
- R8: The summary register at 05h carries `peer_req[5]`,`[4]`,`[3]`,`[2]`,`[1]`,`[0]` on bits 7,5,4,3,2,1. Bit 0 latches `sec_tick` and clears when a read returns it as 1. A tick that arrives in the same cycle as that read keeps bit 0 set.
- R9: `irq` is 1 one cycle after any summary bit is 1. It drops one cycle after the last summary bit clears.
- R10: Writes to 05h, 44h and 46h change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_lof_timeout | input | 1 | Strobe: loss-of-frame timer expired |
| evt_frame_acq | input | 1 | Strobe: frame alignment acquired |
| evt_frame_err | input | 1 | Strobe: framing errors, alignment lost |
| sec_tick | input | 1 | One-second tick strobe |
| peer_req | input | 6 | Request levels of the other summary sources |
| bus_addr | input | 8 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| lof_pin | output | 1 | High while Un-framed |
| oof_pin | output | 1 | High while not In-frame |
| irq | output | 1 | Active-high interrupt |

## Verification
A wrong framing state shows on `lof_pin`, `oof_pin` and the 44h field in the cycle after the strobe that caused it. The bench checks the pins and the 44h field after every strobe, including strobes that must be ignored in the current state. A flag that sets, fails to set or clears wrongly shows on the next read of 46h, and for enabled flags on `irq` one cycle later. The same-cycle read-and-event cases are driven explicitly, because a lost event in that cycle would otherwise only show much later.

// File: rtl/frm_irq_pkg.sv
package frm_irq_pkg;
  typedef enum logic [1:0] {
    FS_OOF = 2'd0,
    FS_UNF = 2'd1,
    FS_INF = 2'd2
  } frm_state_e;

  localparam int NUM_CHG   = 2;
  localparam int CHG_LOF   = 0;
  localparam int CHG_OOF   = 1;
  localparam int NUM_PEER  = 6;
  localparam int SUM_W     = 8;
  localparam int SUM_FRM   = 6;
  localparam int SUM_SEC   = 0;
endpackage

// File: rtl/frm_state_tracker.sv
module frm_state_tracker
  import frm_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evt_lost,
  input  logic               evt_acq,
  input  logic               evt_err,
  output logic               lof_o,
  output logic               oof_o,
  output logic [NUM_CHG-1:0] chg_o
);
  frm_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      FS_OOF:  if (evt_lost) st_d = FS_UNF;
      FS_UNF:  if (evt_acq)  st_d = FS_INF;
      FS_INF:  if (evt_err)  st_d = FS_OOF;
      default: st_d = FS_OOF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= FS_OOF;
    else        st_q <= st_d;
  end

  // change events coincide with the edge that commits the new state
  always_comb begin
    chg_o = '0;
    chg_o[CHG_LOF] = (st_q == FS_OOF && st_d == FS_UNF) ||
                     (st_q == FS_UNF && st_d == FS_INF);
    chg_o[CHG_OOF] = (st_q == FS_UNF && st_d == FS_INF) ||
                     (st_q == FS_INF && st_d == FS_OOF);
  end

  assign lof_o = (st_q == FS_UNF);
  assign oof_o = (st_q != FS_INF);

  AST_LOF_NEEDS_OOF: assert property (@(posedge clk) disable iff (!rst_n)
    lof_o |-> oof_o);                                           // R3
  AST_INF_FROM_UNF: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oof_o) |-> $past(lof_o));                             // R2
  AST_UNF_FROM_OOF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lof_o) |-> ($past(oof_o) && !$past(lof_o)));          // R2
endmodule

// File: rtl/frm_event_flags.sv
module frm_event_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] flag_o,
  output logic         req_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk) begin
      if (!rst_n)        f_q <= 1'b0;
      else if (set_i[i]) f_q <= 1'b1;
      else if (clr_i[i]) f_q <= 1'b0;
    end
    assign flag_o[i] = f_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> flag_o[i]);                                  // R6
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !flag_o[i]);                  // R6
  end

  assign req_o = |(flag_o & en_i);
endmodule

// File: rtl/frm_irq_summary.sv
module frm_irq_summary
  import frm_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PEER-1:0] peer_req,
  input  logic                frm_req,
  input  logic                sec_req,
  output logic [SUM_W-1:0]    sum_o,
  output logic                irq_o
);
  // peer lines fill the summary slots left free by the framing and tick bits
  localparam int PEER_POS [NUM_PEER] = '{1, 2, 3, 4, 5, 7};

  always_comb begin
    sum_o = '0;
    for (int k = 0; k < NUM_PEER; k++) sum_o[PEER_POS[k]] = peer_req[k];
    sum_o[SUM_FRM] = frm_req;
    sum_o[SUM_SEC] = sec_req;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |sum_o;
  end

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_req || sec_req) |=> irq_o);                            // R9
  AST_IRQ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (!frm_req && !sec_req && peer_req == '0) |=> !irq_o);       // R9
endmodule

// File: rtl/frm_irq_ctrl.sv
module frm_irq_ctrl
  import frm_irq_pkg::*;
#(
  parameter int          ADDR_W = 8,
  parameter int          DATA_W = 8,
  parameter logic [7:0]  A_SUM  = 8'h05,
  parameter logic [7:0]  A_CFG  = 8'h44,
  parameter logic [7:0]  A_STAT = 8'h46,
  parameter logic [7:0]  A_EN   = 8'h47
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                evt_lof_timeout,
  input  logic                evt_frame_acq,
  input  logic                evt_frame_err,
  input  logic                sec_tick,
  input  logic [NUM_PEER-1:0] peer_req,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                lof_pin,
  output logic                oof_pin,
  output logic                irq
);
  localparam logic [ADDR_W-1:0] SUM_A  = ADDR_W'(A_SUM);
  localparam logic [ADDR_W-1:0] CFG_A  = ADDR_W'(A_CFG);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(A_STAT);
  localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(A_EN);

  logic [NUM_CHG-1:0] chg, flags, en_q;
  logic               frm_req, sec_flag, sec_req;
  logic [SUM_W-1:0]   sum;
  logic               rd_sum, rd_stat, wr_en;
  logic               unused_wdata_hi;

  assign rd_sum  = bus_rd && (bus_addr == SUM_A);
  assign rd_stat = bus_rd && (bus_addr == STAT_A);
  assign wr_en   = bus_wr && (bus_addr == EN_A);
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_CHG];

  frm_state_tracker u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_lost (evt_lof_timeout),
    .evt_acq  (evt_frame_acq),
    .evt_err  (evt_frame_err),
    .lof_o    (lof_pin),
    .oof_o    (oof_pin),
    .chg_o    (chg)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= bus_wdata[NUM_CHG-1:0];
  end

  frm_event_flags #(.N(NUM_CHG)) u_chg_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (chg),
    .clr_i  ({NUM_CHG{rd_stat}} & flags),
    .en_i   (en_q),
    .flag_o (flags),
    .req_o  (frm_req)
  );

  frm_event_flags #(.N(1)) u_sec_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (sec_tick),
    .clr_i  (rd_sum && sec_flag),
    .en_i   (1'b1),
    .flag_o (sec_flag),
    .req_o  (sec_req)
  );

  frm_irq_summary u_sum (
    .clk      (clk),
    .rst_n    (rst_n),
    .peer_req (peer_req),
    .frm_req  (frm_req),
    .sec_req  (sec_req),
    .sum_o    (sum),
    .irq_o    (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr == SUM_A)       bus_rdata = DATA_W'(sum);
      else if (bus_addr == STAT_A) bus_rdata[NUM_CHG-1:0] = flags;
      else if (bus_addr == EN_A)   bus_rdata[NUM_CHG-1:0] = en_q;
      else if (bus_addr == CFG_A) begin
        bus_rdata[2] = oof_pin;
        bus_rdata[1] = lof_pin;
      end
    end
  end

  AST_RO_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != EN_A) |=> $stable(en_q));            // R10
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !sum[SUM_FRM]);                             // R7
endmodule

// File: tb/tb_frm_irq_ctrl.sv
module tb_frm_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt_lof_timeout = 1'b0, evt_frame_acq = 1'b0, evt_frame_err = 1'b0;
  logic       sec_tick = 1'b0;
  logic [5:0] peer_req = '0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_rdata;
  logic       lof_pin, oof_pin, irq;

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] exp; string tag; } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  frm_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .evt_lof_timeout(evt_lof_timeout), .evt_frame_acq(evt_frame_acq),
    .evt_frame_err(evt_frame_err), .sec_tick(sec_tick), .peer_req(peer_req),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lof_pin(lof_pin), .oof_pin(oof_pin), .irq(irq)
  );

  // monitor: pops one expected read per read cycle, half a period after the driver
  always @(negedge clk) begin
    if (bus_rd && !done) begin
      vectors++;
      if (q.size() == 0) begin
        miscompares++;
        $display("FAIL unexpected read: got %02h expected none", bus_rdata);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (bus_rdata !== e.exp) begin
          miscompares++;
          $display("FAIL %s: read got %02h expected %02h", e.tag, bus_rdata, e.exp);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic got, input logic exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    @(posedge clk); #5;
    bus_addr = a; bus_rd = 1'b1;
    q.push_back('{e, tag});
    @(posedge clk); #5;
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #5;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #5;
    bus_wr = 1'b0;
  endtask

  // 0 = lof timeout, 1 = frame acquired, 2 = frame error, 3 = second tick
  task automatic strobe(input int which);
    @(posedge clk); #5;
    case (which)
      0: evt_lof_timeout = 1'b1;
      1: evt_frame_acq   = 1'b1;
      2: evt_frame_err   = 1'b1;
      default: sec_tick  = 1'b1;
    endcase
    @(posedge clk); #5;
    evt_lof_timeout = 1'b0; evt_frame_acq = 1'b0;
    evt_frame_err = 1'b0; sec_tick = 1'b0;
  endtask

  task automatic finish_run();
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk); #5;
    rst_n = 1'b1;
    #1;
    chk("R1 lof_pin", lof_pin, 1'b0);
    chk("R1 oof_pin", oof_pin, 1'b1);
    chk("R1 irq", irq, 1'b0);
    rd(8'h44, 8'h04, "R1 state OOF");
    rd(8'h47, 8'h00, "R1 enable reset");
    rd(8'h46, 8'h00, "R1 flags reset");
    rd(8'h05, 8'h00, "R1 summary reset");

    // ignored strobes in Out-of-Frame
    strobe(1); strobe(2);
    rd(8'h44, 8'h04, "R2 OOF ignores acq/err");
    rd(8'h46, 8'h00, "R2 no flag on ignored strobe");

    // enable readback layout
    wr(8'h47, 8'hFF);
    rd(8'h47, 8'h03, "R7 enable readback");
    wr(8'h47, 8'h00);

    // OOF -> UNF with enables off
    strobe(0);
    chk("R3 lof_pin UNF", lof_pin, 1'b1);
    chk("R3 oof_pin UNF", oof_pin, 1'b1);
    rd(8'h44, 8'h06, "R3 state UNF");
    chk("R7 irq masked", irq, 1'b0);
    rd(8'h05, 8'h00, "R7 summary masked");
    strobe(2);
    rd(8'h44, 8'h06, "R2 UNF ignores err");
    rd(8'h46, 8'h01, "R4 OOF->UNF sets bit0");
    rd(8'h46, 8'h00, "R6 read clears");

    // UNF -> INF with enables on
    wr(8'h47, 8'h03);
    strobe(1);
    chk("R3 lof_pin INF", lof_pin, 1'b0);
    chk("R3 oof_pin INF", oof_pin, 1'b0);
    @(posedge clk); #5;
    chk("R9 irq rises", irq, 1'b1);
    rd(8'h44, 8'h00, "R3 state INF");
    rd(8'h05, 8'h40, "R7 summary bit6");
    strobe(0);
    rd(8'h44, 8'h00, "R2 INF ignores lof timeout");
    rd(8'h46, 8'h03, "R4 R5 UNF->INF sets both");
    chk("R9 irq held one cycle", irq, 1'b1);
    @(posedge clk); #5;
    chk("R9 irq drops", irq, 1'b0);

    // INF -> OOF
    strobe(2);
    chk("R3 oof_pin back", oof_pin, 1'b1);
    rd(8'h44, 8'h04, "R2 INF->OOF");
    rd(8'h46, 8'h02, "R5 INF->OOF sets bit1");

    // set wins over read clear
    strobe(0);
    @(posedge clk); #5;
    bus_addr = 8'h46; bus_rd = 1'b1; evt_frame_acq = 1'b1;
    q.push_back('{8'h01, "R6 read during event"});
    @(posedge clk); #5;
    bus_rd = 1'b0; evt_frame_acq = 1'b0;

    // writes to read-only registers
    wr(8'h46, 8'h00);
    wr(8'h05, 8'hFF);
    wr(8'h44, 8'hFF);
    rd(8'h46, 8'h03, "R6 R10 flag kept");
    rd(8'h44, 8'h00, "R10 state unchanged");
    rd(8'h47, 8'h03, "R10 enable unchanged");

    // partial enable
    wr(8'h47, 8'h02);
    strobe(2);
    rd(8'h05, 8'h40, "R7 bit1 enabled");
    wr(8'h47, 8'h00);
    rd(8'h05, 8'h00, "R7 disabled summary");
    chk("R9 irq off when masked", irq, 1'b0);
    rd(8'h46, 8'h02, "R7 flag latched while masked");
    rd(8'h46, 8'h00, "R6 cleared");

    // one-second flag
    strobe(3);
    @(posedge clk); #5;
    chk("R9 irq from tick", irq, 1'b1);
    rd(8'h05, 8'h01, "R8 tick latched");
    rd(8'h05, 8'h00, "R8 tick cleared");
    strobe(3);
    @(posedge clk); #5;
    bus_addr = 8'h05; bus_rd = 1'b1; sec_tick = 1'b1;
    q.push_back('{8'h01, "R8 read with tick"});
    @(posedge clk); #5;
    bus_rd = 1'b0; sec_tick = 1'b0;
    rd(8'h05, 8'h01, "R8 tick set wins");
    rd(8'h05, 8'h00, "R8 tick cleared again");

    // peer request mapping
    peer_req = 6'b101010;
    rd(8'h05, 8'h94, "R8 peer map A");
    chk("R9 irq from peer", irq, 1'b1);
    peer_req = 6'b010101;
    rd(8'h05, 8'h2A, "R8 peer map B");
    peer_req = 6'b000000;
    @(posedge clk); #5;
    @(posedge clk); #5;
    chk("R9 irq idle", irq, 1'b0);

    wait (q.size() == 0);
    finish_run();
  end
endmodule